// File: doc/BRIEF.md
# UART Receive DMA Engine

This block moves received UART bytes into memory. It does not do the bit-level deserialisation. A receiver in front of it hands over whole bytes through a one-cycle valid strobe. Each byte goes into a small internal FIFO, and the FIFO drains one byte per accepted transfer on a simple valid/ready memory write port. The write address is the current buffer base plus the number of bytes already placed in that buffer.

Software controls the engine with single-cycle task pulses: start, stop and flush. It prepares each buffer by writing a pending base address and length. The pending pair is copied into the active pair only when a start takes effect, so the next buffer can be set up while the current one is filling.

An end-of-buffer event fires when a buffer fills, when reception is stopped, or when a flush completes. The received-amount output changes only at that moment. A shortcut input turns every end of reception into an immediate restart. With the shortcut, buffers chain with no byte lost. Bytes still waiting in the FIFO always go to the new buffer first.

Top module: `rxdma_engine`

## Requirements
- R1: While a buffer is active, bytes are written in arrival order to address base+index, one per accepted handshake. `mem_valid` only asserts when the FIFO holds a byte. Address and data stay stable while the memory stalls.
- R2: Bytes left in the FIFO when a buffer ends are written at the start of the next buffer, ahead of any byte received later.
- R3: The base/length written through `cfg_wr` is pending. It takes effect only at a start (or flush). Rewriting it during reception does not move the active buffer.
- R4: A start pulse while a buffer is active is ignored.
- R5: When the byte count reaches the active length, `ev_end` pulses, `amount` equals the length, and no further write is issued until the next start. The receiver stays enabled, so new bytes wait in the FIFO.
- R6: `amount` keeps its value during reception. It changes only in the cycle where `ev_end` is high.
- R7: With `auto_restart` high, every end of an active buffer (full or stopped) immediately restarts into the pending buffer.
- R8: A stop pulse on an active buffer raises `ev_end` with `amount` equal to the bytes written so far. It disables the receiver, so bytes arriving afterwards are ignored (no `ev_rxrdy`, no write).
- R9: A flush pulse while idle writes the FIFO contents to the pending base as a new transfer. When the FIFO is empty it raises `ev_end` with `amount` equal to the number of bytes flushed.
- R10: The FIFO holds 4 bytes. A byte arriving with the FIFO full is dropped and sets the sticky `overrun` flag. A software start clears the flag.
- R11: `ev_rxrdy` pulses one cycle after each byte accepted into the FIFO. This can be before the byte is written to memory.
- R12: After reset all outputs are low or zero and the receiver is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | DW | Received byte |
| cfg_wr | input | 1 | Write pending base and length |
| cfg_ptr | input | AW | Pending buffer base address |
| cfg_len | input | LW | Pending buffer length in bytes (at least 1) |
| task_start | input | 1 | Start task pulse |
| task_stop | input | 1 | Stop task pulse |
| task_flush | input | 1 | Flush task pulse |
| auto_restart | input | 1 | Restart on end-of-buffer shortcut |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | AW | Write address |
| mem_data | output | DW | Write data |
| ev_rxrdy | output | 1 | Byte accepted into the FIFO event |
| ev_end | output | 1 | End-of-buffer event |
| amount | output | LW | Bytes in the last finished transfer |
| overrun | output | 1 | Sticky FIFO overrun flag |

## Verification
`ev_rxrdy` and the FIFO push come from the edge that accepts a byte. The first write request for that byte is therefore visible in the cycle after that edge. `ev_end` and `amount` both register at the edge of the final handshake, stop or flush completion, so they appear together one cycle later. The bench drives inputs 1 ns after the rising edge and samples everything on the falling edge. It counts writes, byte events and end events as they occur, and waits on those counters instead of fixed delays. Memory contents are compared only after the relevant `ev_end` has been seen.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RUN   = 2'd1,
      ST_FLUSH = 2'd2
   } rxdma_state_e;
endpackage

// File: rtl/rxdma_fifo.sv
module rxdma_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   logic [W-1:0]  store_q [DEPTH];
   logic [PW-1:0] rd_q, wr_q, rd_nx, wr_nx;
   logic [CW-1:0] fill_q;

   generate
      if (POW2) begin : g_wrap_free
         assign rd_nx = rd_q + 1'b1;
         assign wr_nx = wr_q + 1'b1;
      end else begin : g_wrap_cmp
         assign rd_nx = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
         assign wr_nx = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) store_q[wr_q] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q   <= '0;
         wr_q   <= '0;
         fill_q <= '0;
      end else begin
         if (push) wr_q <= wr_nx;
         if (pop)  rd_q <= rd_nx;
         case ({push, pop})
            2'b10:   fill_q <= fill_q + 1'b1;
            2'b01:   fill_q <= fill_q - 1'b1;
            default: fill_q <= fill_q;
         endcase
      end
   end

   assign dout  = store_q[rd_q];
   assign empty = (fill_q == '0);
   assign full  = (fill_q == CW'(DEPTH));
endmodule

// File: rtl/rxdma_ptrbank.sv
module rxdma_ptrbank #(
   parameter int AW = 16,
   parameter int LW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_wr,
   input  logic [AW-1:0] cfg_ptr,
   input  logic [LW-1:0] cfg_len,
   input  logic          take,
   output logic [AW-1:0] cur_ptr,
   output logic [LW-1:0] cur_len
);
   logic [AW-1:0] pend_ptr_q;
   logic [LW-1:0] pend_len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_ptr_q <= '0;
         pend_len_q <= '0;
         cur_ptr    <= '0;
         cur_len    <= '0;
      end else begin
         if (cfg_wr) begin
            pend_ptr_q <= cfg_ptr;
            pend_len_q <= cfg_len;
         end
         if (take) begin
            cur_ptr <= pend_ptr_q;
            cur_len <= pend_len_q;
         end
      end
   end
endmodule

// File: rtl/rxdma_ctrl.sv
module rxdma_ctrl
   import rxdma_pkg::*;
#(
   parameter int LW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          task_start,
   input  logic          task_stop,
   input  logic          task_flush,
   input  logic          auto_restart,
   input  logic          fifo_empty,
   input  logic          wr_fire,
   input  logic [LW-1:0] cur_len,
   output rxdma_state_e  state,
   output logic          take,
   output logic [LW-1:0] count,
   output logic [LW-1:0] amount,
   output logic          ev_end,
   output logic          rx_en,
   output logic          clr_ovr
);
   logic [LW-1:0] cnt_inc, amt_run;
   logic end_full, end_stop, end_run, end_flush, restart, do_start, do_flush;

   always_comb begin
      cnt_inc   = count + 1'b1;
      end_full  = (state == ST_RUN) && wr_fire && (cnt_inc == cur_len);
      end_stop  = (state == ST_RUN) && task_stop && !end_full;
      end_run   = end_full || end_stop;
      amt_run   = wr_fire ? cnt_inc : count;
      end_flush = (state == ST_FLUSH) && fifo_empty;
      restart   = end_run && auto_restart;
      do_start  = (task_start && (state == ST_IDLE)) || restart;
      do_flush  = task_flush && !task_start && (state == ST_IDLE);
      take      = do_start || do_flush;
      clr_ovr   = task_start && (state == ST_IDLE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         count  <= '0;
         amount <= '0;
         ev_end <= 1'b0;
         rx_en  <= 1'b0;
      end else begin
         ev_end <= end_run || end_flush;
         if (end_run)        amount <= amt_run;
         else if (end_flush) amount <= count;

         if (do_start || do_flush) count <= '0;
         else if (wr_fire)         count <= cnt_inc;

         if (do_start)       rx_en <= 1'b1;
         else if (task_stop) rx_en <= 1'b0;

         if (restart)        state <= ST_RUN;
         else if (end_run)   state <= ST_IDLE;
         else if (do_start)  state <= ST_RUN;
         else if (do_flush)  state <= ST_FLUSH;
         else if (end_flush) state <= ST_IDLE;
      end
   end
endmodule

// File: rtl/rxdma_engine.sv
module rxdma_engine
   import rxdma_pkg::*;
#(
   parameter int DW         = 8,
   parameter int AW         = 16,
   parameter int LW         = 8,
   parameter int FIFO_DEPTH = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_valid,
   input  logic [DW-1:0] rx_byte,
   input  logic          cfg_wr,
   input  logic [AW-1:0] cfg_ptr,
   input  logic [LW-1:0] cfg_len,
   input  logic          task_start,
   input  logic          task_stop,
   input  logic          task_flush,
   input  logic          auto_restart,
   output logic          mem_valid,
   input  logic          mem_ready,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_data,
   output logic          ev_rxrdy,
   output logic          ev_end,
   output logic [LW-1:0] amount,
   output logic          overrun
);
   generate
      if (FIFO_DEPTH < 2) begin : g_bad_depth
         $error("rxdma_engine: FIFO_DEPTH must be at least 2");
      end
      if (LW < 2 || LW > AW) begin : g_bad_len
         $error("rxdma_engine: LW must be in 2..AW");
      end
      if (DW < 1) begin : g_bad_dw
         $error("rxdma_engine: DW must be positive");
      end
   endgenerate

   rxdma_state_e  state;
   logic          take, rx_en, clr_ovr, fifo_empty, fifo_full, wr_fire, push;
   logic [AW-1:0] cur_ptr;
   logic [LW-1:0] cur_len, count;

   assign push    = rx_valid && rx_en && !fifo_full;
   assign wr_fire = mem_valid && mem_ready;

   rxdma_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .din   (rx_byte),
      .pop   (wr_fire),
      .dout  (mem_data),
      .empty (fifo_empty),
      .full  (fifo_full)
   );

   rxdma_ptrbank #(.AW(AW), .LW(LW)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg_wr  (cfg_wr),
      .cfg_ptr (cfg_ptr),
      .cfg_len (cfg_len),
      .take    (take),
      .cur_ptr (cur_ptr),
      .cur_len (cur_len)
   );

   rxdma_ctrl #(.LW(LW)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .task_start   (task_start),
      .task_stop    (task_stop),
      .task_flush   (task_flush),
      .auto_restart (auto_restart),
      .fifo_empty   (fifo_empty),
      .wr_fire      (wr_fire),
      .cur_len      (cur_len),
      .state        (state),
      .take         (take),
      .count        (count),
      .amount       (amount),
      .ev_end       (ev_end),
      .rx_en        (rx_en),
      .clr_ovr      (clr_ovr)
   );

   assign mem_valid = (state != ST_IDLE) && !fifo_empty;
   assign mem_addr  = cur_ptr + AW'(count);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ev_rxrdy <= 1'b0;
         overrun  <= 1'b0;
      end else begin
         ev_rxrdy <= push;
         if (clr_ovr)                              overrun <= 1'b0;
         else if (rx_valid && rx_en && fifo_full)  overrun <= 1'b1;
      end
   end
endmodule

// File: rtl/rxdma_checker.sv
module rxdma_checker
   import rxdma_pkg::*;
#(
   parameter int DW = 8,
   parameter int AW = 16,
   parameter int LW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rx_valid,
   input logic          task_start,
   input logic          task_stop,
   input logic          mem_valid,
   input logic          mem_ready,
   input logic [AW-1:0] mem_addr,
   input logic [DW-1:0] mem_data,
   input logic          ev_rxrdy,
   input logic          ev_end,
   input logic [LW-1:0] amount,
   input logic          overrun,
   input rxdma_state_e  state,
   input logic [AW-1:0] cur_ptr,
   input logic [LW-1:0] cur_len,
   input logic [LW-1:0] count
);
   AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready && !task_stop) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data))); // R1
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN && task_start && !task_stop && !(mem_valid && mem_ready)) |=> ($stable(cur_ptr) && $stable(cur_len))); // R4
   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN && cur_len != '0) |-> (count < cur_len)); // R5
   AST_AMOUNT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(amount) |-> ev_end); // R6
   AST_DROP_NO_RXRDY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun) |-> !ev_rxrdy); // R10
   AST_RXRDY_FROM_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      ev_rxrdy |-> $past(rx_valid)); // R11
endmodule

bind rxdma_engine rxdma_checker #(.DW(DW), .AW(AW), .LW(LW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rx_valid   (rx_valid),
   .task_start (task_start),
   .task_stop  (task_stop),
   .mem_valid  (mem_valid),
   .mem_ready  (mem_ready),
   .mem_addr   (mem_addr),
   .mem_data   (mem_data),
   .ev_rxrdy   (ev_rxrdy),
   .ev_end     (ev_end),
   .amount     (amount),
   .overrun    (overrun),
   .state      (state),
   .cur_ptr    (cur_ptr),
   .cur_len    (cur_len),
   .count      (count)
);

// File: tb/tb_rxdma_engine.sv
`timescale 1ns/100ps
module tb_rxdma_engine;
   localparam int DW = 8, AW = 16, LW = 8;

   logic          clk = 1'b0, rst_n = 1'b0;
   logic          rx_valid = 1'b0, cfg_wr = 1'b0;
   logic [DW-1:0] rx_byte = '0;
   logic [AW-1:0] cfg_ptr = '0;
   logic [LW-1:0] cfg_len = '0;
   logic          task_start = 1'b0, task_stop = 1'b0, task_flush = 1'b0;
   logic          auto_restart = 1'b0, mem_ready = 1'b1;
   logic          mem_valid, ev_rxrdy, ev_end, overrun;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_data;
   logic [LW-1:0] amount;

   int checks = 0, fails = 0, n_wr = 0, n_rdy = 0, n_end = 0;
   logic [7:0] bmem [4096];

   always #2.5 clk = ~clk;

   rxdma_engine #(.DW(DW), .AW(AW), .LW(LW), .FIFO_DEPTH(4)) dut (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
      .cfg_wr(cfg_wr), .cfg_ptr(cfg_ptr), .cfg_len(cfg_len),
      .task_start(task_start), .task_stop(task_stop), .task_flush(task_flush),
      .auto_restart(auto_restart), .mem_valid(mem_valid), .mem_ready(mem_ready),
      .mem_addr(mem_addr), .mem_data(mem_data), .ev_rxrdy(ev_rxrdy),
      .ev_end(ev_end), .amount(amount), .overrun(overrun)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_valid && mem_ready) begin
            bmem[mem_addr[11:0]] = mem_data;
            n_wr++;
         end
         if (ev_rxrdy) n_rdy++;
         if (ev_end)   n_end++;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic send(input logic [7:0] b);
      rx_valid = 1'b1; rx_byte = b; tick(); rx_valid = 1'b0; tick();
   endtask

   task automatic cfg(input int p, input int l);
      cfg_wr = 1'b1; cfg_ptr = AW'(p); cfg_len = LW'(l); tick(); cfg_wr = 1'b0;
   endtask

   task automatic do_start();
      task_start = 1'b1; tick(); task_start = 1'b0;
   endtask

   task automatic do_stop();
      task_stop = 1'b1; tick(); task_stop = 1'b0;
   endtask

   task automatic do_flush();
      task_flush = 1'b1; tick(); task_flush = 1'b0;
   endtask

   task automatic wait_end(input int target, input string req);
      int g = 0;
      while (n_end < target && g < 2000) begin tick(); g++; end
      chk(n_end >= target, req, n_end, target);
      ticks(2);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(mem_valid == 1'b0, "R12 mem_valid", mem_valid, 0);
      chk(ev_end == 1'b0 && ev_rxrdy == 1'b0, "R12 events", {ev_end, ev_rxrdy}, 0);
      chk(amount == '0, "R12 amount", amount, 0);
      chk(overrun == 1'b0, "R12 overrun", overrun, 0);
      rx_valid = 1'b1; rx_byte = 8'h77; tick(); rx_valid = 1'b0; ticks(3);
      chk(n_rdy == 0 && n_wr == 0, "R12 receiver disabled", n_rdy + n_wr, 0);
   endtask

   task automatic t_fill();
      int e0 = n_end, r0 = n_rdy, w0;
      mem_ready = 1'b1;
      cfg(16'h100, 4); do_start();
      send(8'hA0); send(8'hA1);
      chk(amount == '0, "R6 amount held during reception", amount, 0);
      send(8'hA2); send(8'hA3);
      wait_end(e0 + 1, "R5 end on full");
      chk(amount == 8'd4, "R5 amount", amount, 4);
      for (int i = 0; i < 4; i++)
         chk(bmem[12'h100 + i] == 8'hA0 + i, "R1 data order", bmem[12'h100 + i], 8'hA0 + i);
      chk(n_rdy - r0 == 4, "R11 rxrdy count", n_rdy - r0, 4);
      w0 = n_wr;
      send(8'hC0); ticks(5);
      chk(n_wr == w0, "R5 no write after full", n_wr - w0, 0);
      chk(n_rdy - r0 == 5, "R5 receiver still on", n_rdy - r0, 5);
   endtask

   task automatic t_carry_and_ignore();
      int e0 = n_end;
      cfg(16'h200, 6); do_start();
      send(8'hB1); send(8'hB2);
      cfg(16'h300, 6); do_start();
      send(8'hB3); send(8'hB4); send(8'hB5);
      wait_end(e0 + 1, "R4 end");
      chk(bmem[12'h200] == 8'hC0, "R2 carried byte first", bmem[12'h200], 8'hC0);
      for (int i = 1; i < 6; i++)
         chk(bmem[12'h200 + i] == 8'hB0 + i, "R3 active buffer kept", bmem[12'h200 + i], 8'hB0 + i);
      chk(bmem[12'h300] == 8'h00, "R4 start ignored", bmem[12'h300], 0);
      chk(amount == 8'd6, "R4 amount", amount, 6);
   endtask

   task automatic t_chain();
      int e0 = n_end;
      mem_ready = 1'b0; auto_restart = 1'b1;
      cfg(16'h400, 3); do_start(); cfg(16'h500, 3);
      for (int i = 0; i < 4; i++) send(8'hD0 + 8'(i));
      chk(overrun == 1'b0, "R10 four bytes fit", overrun, 0);
      mem_ready = 1'b1;
      wait_end(e0 + 1, "R7 first end");
      auto_restart = 1'b0;
      send(8'hD4); send(8'hD5);
      wait_end(e0 + 2, "R7 second end");
      for (int i = 0; i < 3; i++) begin
         chk(bmem[12'h400 + i] == 8'hD0 + i, "R7 first buffer", bmem[12'h400 + i], 8'hD0 + i);
         chk(bmem[12'h500 + i] == 8'hD3 + i, "R2 R7 second buffer", bmem[12'h500 + i], 8'hD3 + i);
      end
      chk(amount == 8'd3, "R7 amount", amount, 3);
   endtask

   task automatic t_overrun();
      int e0 = n_end, r0 = n_rdy, w0 = n_wr;
      mem_ready = 1'b0;
      cfg(16'h600, 8); do_start();
      for (int i = 0; i < 5; i++) send(8'hE0 + 8'(i));
      chk(overrun == 1'b1, "R10 overrun set", overrun, 1);
      chk(n_rdy - r0 == 4, "R10 dropped byte no rxrdy", n_rdy - r0, 4);
      chk(n_wr == w0, "R11 rxrdy before write", n_wr - w0, 0);
      mem_ready = 1'b1; ticks(8);
      do_stop();
      wait_end(e0 + 1, "R8 stop end");
      chk(amount == 8'd4, "R8 amount", amount, 4);
      chk(bmem[12'h603] == 8'hE3 && bmem[12'h604] == 8'h00, "R10 fifth dropped", bmem[12'h604], 0);
      chk(overrun == 1'b1, "R10 sticky", overrun, 1);
      cfg(16'h680, 8); do_start();
      chk(overrun == 1'b0, "R10 cleared by start", overrun, 0);
      do_stop(); ticks(3); e0 = n_end;
   endtask

   task automatic t_flush();
      int e0 = n_end, r0;
      mem_ready = 1'b0;
      cfg(16'h700, 8); do_start();
      send(8'hF0); send(8'hF1); send(8'hF2);
      do_stop();
      wait_end(e0 + 1, "R8 early end");
      chk(amount == 8'd0, "R8 amount zero", amount, 0);
      r0 = n_rdy;
      send(8'hF9); ticks(2);
      chk(n_rdy == r0, "R8 byte after stop ignored", n_rdy - r0, 0);
      cfg(16'h780, 8); mem_ready = 1'b1; do_flush();
      wait_end(e0 + 2, "R9 flush end");
      chk(amount == 8'd3, "R9 amount", amount, 3);
      for (int i = 0; i < 3; i++)
         chk(bmem[12'h780 + i] == 8'hF0 + i, "R9 flushed data", bmem[12'h780 + i], 8'hF0 + i);
      chk(bmem[12'h783] == 8'h00 && bmem[12'h700] == 8'h00, "R9 nothing extra", bmem[12'h783], 0);
   endtask

   task automatic t_stop_chain();
      int e0 = n_end;
      mem_ready = 1'b1; auto_restart = 1'b1;
      cfg(16'h800, 8); do_start(); cfg(16'h880, 8);
      send(8'h31); send(8'h32); ticks(3);
      do_stop();
      wait_end(e0 + 1, "R7 stop restart");
      chk(amount == 8'd2, "R7 stopped amount", amount, 2);
      send(8'h33); ticks(3);
      chk(bmem[12'h880] == 8'h33, "R7 continued into next", bmem[12'h880], 8'h33);
      auto_restart = 1'b0; do_stop();
      wait_end(e0 + 2, "R8 final stop");
      chk(amount == 8'd1, "R8 final amount", amount, 1);
   endtask

   initial begin
      #(200000 * 5);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < 4096; i++) bmem[i] = 8'h00;
      ticks(4);
      rst_n = 1'b1;
      tick();
      t_reset();
      t_fill();
      t_carry_and_ignore();
      t_chain();
      t_overrun();
      t_flush();
      t_stop_chain();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule